// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO Core

This block is an 18-bit first-in first-out buffer with a write port and a read port on unrelated clocks. Each side keeps its own binary pointer plus a registered Gray copy. The Gray copy reaches the other side through two flip-flops and is turned back into binary there. Because of this crossing, every flag that depends on the far side can lag by one extra cycle of the observing clock. A flag never shows a state that has not yet been reached.

While `rst_n` is low, the read side takes a three-bit configuration code on each read-clock edge and latches a read behaviour. In standard behaviour a stored word leaves the buffer only on a read request, and `rd_stall` works as an empty flag. In fall-through behaviour the oldest word is moved to `rd_data` with no request, and `rd_stall` low means the word on `rd_data` is valid. A read request then consumes that word. Both behaviours share one read state machine with the states RD_CFG, RD_DRY and RD_LIVE. Its transitions are:
- CFG_TO_DRY, on the first edge after reset.
- DRY_TO_LIVE, when a word becomes visible.
- LIVE_TO_DRY, when the last visible word is consumed.
- LIVE_STAY, on a read request with further words available.

The write side has the states WR_CFG, WR_OPEN and WR_FULL. Its transitions are:
- CFG_TO_OPEN, on the first edge after reset.
- OPEN_TO_FULL, when the stored count reaches the depth.
- FULL_TO_OPEN, once the read pointer is seen to move.

The write side also drives half-full and almost-full flags. The read side drives an almost-empty flag. The two almost thresholds are loaded over a parallel offset port on the write clock.

Top module: `dsf_core`

## Requirements
- R1: The read behaviour is chosen by `cfg_code` (bit 2 first-load, bit 1 read-expansion, bit 0 write-expansion). The codes 3'b001 and 3'b101 select fall-through, and every other code selects standard. The code is sampled on read-clock edges only while `rst_n` is low. Changing it afterwards has no effect until the next reset.
- R2: After reset, and before any write, the outputs are as follows: `rd_stall`=1, `wr_block`=0, `half_full`=0, `almost_full`=0, `almost_empty`=1 and `rd_data`=0.
- R3: In standard behaviour, `rd_stall` falls within four read-clock edges after the write edge that stores a word into an empty buffer. `rd_data` changes only on a read-clock edge with `rd_en`=1 and `rd_stall`=0, and it then shows the oldest unread word. Words leave in write order.
- R4: In fall-through behaviour, the oldest word appears on `rd_data` with `rd_stall`=0 without any read request. A read request on an edge with `rd_stall`=0 replaces it with the next word, or sets `rd_stall`=1 if none is visible.
- R5: In standard behaviour, `wr_block` rises once the buffer holds DEPTH unread words. A write attempted while `wr_block`=1 is dropped: neither its data nor any change to the word order is ever seen at the read port.
- R6: A read request while no word is available leaves `rd_data` and the read order unchanged. The next word written is the next word read.
- R7: `half_full` is 1 when the write side counts more than DEPTH/2 stored words, and 0 otherwise.
- R8: `almost_full` is 1 when the write-side count is at least DEPTH minus the almost-full offset. That offset is 7 after reset.
- R9: `almost_empty` is 1 when the read-side count is at most the almost-empty offset. That offset is 7 after reset. In fall-through behaviour the word held on `rd_data` is included in the count.
- R10: A write-clock edge with `ofs_load`=1 stores `ofs_value` as the almost-empty offset when `ofs_sel`=0, and as the almost-full offset when `ofs_sel`=1. The flags then use the new threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously by both clocks |
| cfg_code | input | 3 | Behaviour code, taken only during reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_block | output | 1 | High when a write would be dropped |
| half_full | output | 1 | More than half the depth is occupied |
| almost_full | output | 1 | Occupancy has reached the almost-full threshold |
| ofs_load | input | 1 | Offset load strobe |
| ofs_sel | input | 1 | Offset target: 0 almost-empty, 1 almost-full |
| ofs_value | input | $clog2(DEPTH) | Offset value to load |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Read word |
| rd_stall | output | 1 | High when no valid word is available to the reader |
| almost_empty | output | 1 | Occupancy is at or below the almost-empty threshold |

## Verification
The bench first writes single words and short bursts, with the configuration code changed after reset. This separates request-driven output from fall-through output, and it shows whether the code is still sampled after reset. Bursts then fill the buffer one word at a time. Each flag is examined one word below and at its threshold, which pins down off-by-one errors in the half, almost-full, almost-empty and full comparisons. A complete fill followed by a dropped write and a full drain checks order and capacity. Reads issued against an empty buffer, followed by a fresh write, show whether a refused read disturbs the pointer. Loading offsets that differ from the defaults shows whether the thresholds really follow the loaded values.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

    typedef enum logic [1:0] {
        WR_CFG  = 2'd0,
        WR_OPEN = 2'd1,
        WR_FULL = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        RD_CFG  = 2'd0,
        RD_DRY  = 2'd1,
        RD_LIVE = 2'd2
    } rd_state_e;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FALL = 1'b1
    } rd_mode_e;

    // bit2 first-load, bit1 read-expansion, bit0 write-expansion
    function automatic rd_mode_e decode_mode(input logic [2:0] code);
        rd_mode_e m;
        case (code)
            3'b001, 3'b101: m = MODE_FALL;
            default:        m = MODE_STD;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dsf_ptr_sync.sv
module dsf_ptr_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
        logic [W-1:0] b;
        b[W-1] = g[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    assign bin_out = gray_to_bin(stage2);

endmodule

// File: rtl/dsf_wr_side.sv
module dsf_wr_side
    import dsf_pkg::*;
#(
    parameter int AW          = 8,
    parameter int OFS_DEFAULT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          ofs_load,
    input  logic          ofs_sel,
    input  logic [AW-1:0] ofs_value,
    input  logic [AW:0]   rptr_sync,
    output logic [AW:0]   wptr,
    output logic [AW:0]   wptr_gray,
    output logic          wr_accept,
    output logic          wr_block,
    output logic          half_full,
    output logic          almost_full,
    output logic [AW-1:0] ae_ofs
);

    localparam int          DEPTH    = 1 << AW;
    localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);
    localparam logic [AW:0] CNT_HALF = (AW+1)'(DEPTH / 2);
    localparam logic [AW-1:0] OFS_RST = AW'(OFS_DEFAULT);

    wr_state_e     state;
    wr_state_e     state_n;
    logic [AW-1:0] af_ofs;
    logic [AW:0]   wptr_n;
    logic [AW:0]   cnt_n;
    logic [AW:0]   cnt_now;

    // next-state and pointer advance
    always_comb begin
        wr_accept = wr_en && (state == WR_OPEN);
        wptr_n    = wptr + (AW+1)'(wr_accept);
        cnt_n     = wptr_n - rptr_sync;
        state_n   = state;
        unique case (state)
            WR_CFG:  state_n = WR_OPEN;
            WR_OPEN: if (cnt_n == CNT_FULL) state_n = WR_FULL;
            WR_FULL: if (cnt_n != CNT_FULL) state_n = WR_OPEN;
            default: state_n = WR_CFG;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= WR_CFG;
            wptr      <= '0;
            wptr_gray <= '0;
        end else begin
            state     <= state_n;
            wptr      <= wptr_n;
            wptr_gray <= wptr_n ^ (wptr_n >> 1);
        end
    end

    // registered flags and offsets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_full   <= 1'b0;
            almost_full <= 1'b0;
            af_ofs      <= OFS_RST;
            ae_ofs      <= OFS_RST;
        end else begin
            half_full   <= (cnt_n > CNT_HALF);
            almost_full <= (cnt_n >= (CNT_FULL - {1'b0, af_ofs}));
            if (ofs_load) begin
                if (ofs_sel) af_ofs <= ofs_value;
                else         ae_ofs <= ofs_value;
            end
        end
    end

    assign wr_block = (state != WR_OPEN);
    assign cnt_now  = wptr - rptr_sync;

    // R5: a refused write leaves the write pointer where it was
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_block) |=> $stable(wptr));

    // R5: the write side never counts more than the depth
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_now <= CNT_FULL);

endmodule

// File: rtl/dsf_rd_side.sv
module dsf_rd_side
    import dsf_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 18,
    parameter int OFS_DEFAULT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cfg_code,
    input  logic          rd_en,
    input  logic [AW:0]   wptr_sync,
    input  logic [DW-1:0] mem_q,
    input  logic [AW-1:0] ae_ofs_w,
    output logic [AW:0]   rptr,
    output logic [AW:0]   rptr_gray,
    output logic [DW-1:0] rd_data,
    output logic          rd_stall,
    output logic          almost_empty
);

    localparam int          DEPTH    = 1 << AW;
    localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] OFS_RST = AW'(OFS_DEFAULT);

    rd_state_e     state;
    rd_state_e     state_n;
    rd_mode_e      mode;
    logic          avail;
    logic          load;
    logic          live_word;
    logic [AW:0]   rptr_n;
    logic [AW:0]   cnt_n;
    logic [AW-1:0] ae_s1;
    logic [AW-1:0] ae_s2;

    // next-state: standard and fall-through share the state set
    always_comb begin
        avail   = (wptr_sync != rptr);
        state_n = state;
        load    = 1'b0;
        unique case (state)
            RD_CFG: state_n = RD_DRY;
            RD_DRY: begin
                if (avail) begin
                    state_n = RD_LIVE;
                    load    = (mode == MODE_FALL);
                end
            end
            RD_LIVE: begin
                if (rd_en) begin
                    if (mode == MODE_STD) begin
                        load = 1'b1;
                        if (wptr_sync == rptr + 1'b1) state_n = RD_DRY;
                    end else if (avail) begin
                        load = 1'b1;
                    end else begin
                        state_n = RD_DRY;
                    end
                end
            end
            default: state_n = RD_CFG;
        endcase
        rptr_n    = rptr + (AW+1)'(load);
        live_word = (mode == MODE_FALL) && (state_n == RD_LIVE);
        cnt_n     = (wptr_sync - rptr_n) + (AW+1)'(live_word);
    end

    // state register; behaviour code latched only during reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= decode_mode(cfg_code);
            state     <= RD_CFG;
            rptr      <= '0;
            rptr_gray <= '0;
        end else begin
            state     <= state_n;
            rptr      <= rptr_n;
            rptr_gray <= rptr_n ^ (rptr_n >> 1);
        end
    end

    // outputs: data register, almost-empty flag, offset crossing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data      <= '0;
            almost_empty <= 1'b1;
            ae_s1        <= OFS_RST;
            ae_s2        <= OFS_RST;
        end else begin
            if (load) rd_data <= mem_q;
            almost_empty <= (cnt_n <= {1'b0, ae_s2});
            ae_s1        <= ae_ofs_w;
            ae_s2        <= ae_s1;
        end
    end

    assign rd_stall = (state != RD_LIVE);

    // R1: the latched behaviour cannot change outside reset
    p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode));

    // R6: a standard read with nothing visible moves neither pointer nor data
    p_empty_read_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STD && rd_stall && rd_en) |=> ($stable(rptr) && $stable(rd_data)));

    // R6: the read pointer never runs ahead of the synchronised write pointer
    p_rd_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr_sync - rptr) <= CNT_FULL);

    // R4: presenting a word in fall-through consumes exactly one memory entry
    p_fall_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FALL && $fell(rd_stall)) |-> (rptr == $past(rptr) + 1'b1));

endmodule

// File: rtl/dsf_core.sv
module dsf_core
    import dsf_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int DEPTH       = 256,
    parameter int OFS_DEFAULT = 7
) (
    input  logic                       wclk,
    input  logic                       rclk,
    input  logic                       rst_n,
    input  logic [2:0]                 cfg_code,
    input  logic                       wr_en,
    input  logic [DATA_W-1:0]          wr_data,
    output logic                       wr_block,
    output logic                       half_full,
    output logic                       almost_full,
    input  logic                       ofs_load,
    input  logic                       ofs_sel,
    input  logic [$clog2(DEPTH)-1:0]   ofs_value,
    input  logic                       rd_en,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       rd_stall,
    output logic                       almost_empty
);

    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] mem_q;
    logic [AW:0]       wptr;
    logic [AW:0]       wptr_gray;
    logic [AW:0]       wptr_sync;
    logic [AW:0]       rptr;
    logic [AW:0]       rptr_gray;
    logic [AW:0]       rptr_sync;
    logic              wr_accept;
    logic [AW-1:0]     ae_ofs;

    always_ff @(posedge wclk) begin
        if (wr_accept) mem[wptr[AW-1:0]] <= wr_data;
    end

    assign mem_q = mem[rptr[AW-1:0]];

    dsf_wr_side #(
        .AW          (AW),
        .OFS_DEFAULT (OFS_DEFAULT)
    ) u_wr (
        .clk         (wclk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .ofs_load    (ofs_load),
        .ofs_sel     (ofs_sel),
        .ofs_value   (ofs_value),
        .rptr_sync   (rptr_sync),
        .wptr        (wptr),
        .wptr_gray   (wptr_gray),
        .wr_accept   (wr_accept),
        .wr_block    (wr_block),
        .half_full   (half_full),
        .almost_full (almost_full),
        .ae_ofs      (ae_ofs)
    );

    dsf_ptr_sync #(.W(AW + 1)) u_wsync (
        .clk     (rclk),
        .rst_n   (rst_n),
        .gray_in (wptr_gray),
        .bin_out (wptr_sync)
    );

    dsf_ptr_sync #(.W(AW + 1)) u_rsync (
        .clk     (wclk),
        .rst_n   (rst_n),
        .gray_in (rptr_gray),
        .bin_out (rptr_sync)
    );

    dsf_rd_side #(
        .AW          (AW),
        .DW          (DATA_W),
        .OFS_DEFAULT (OFS_DEFAULT)
    ) u_rd (
        .clk          (rclk),
        .rst_n        (rst_n),
        .cfg_code     (cfg_code),
        .rd_en        (rd_en),
        .wptr_sync    (wptr_sync),
        .mem_q        (mem_q),
        .ae_ofs_w     (ae_ofs),
        .rptr         (rptr),
        .rptr_gray    (rptr_gray),
        .rd_data      (rd_data),
        .rd_stall     (rd_stall),
        .almost_empty (almost_empty)
    );

endmodule

// File: tb/sim_dsf_core.sv
`timescale 1ns/1ps
module sim_dsf_core;

    localparam int DW    = 18;
    localparam int DEPTH = 32;
    localparam int AW    = 5;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cfg_code = 3'b000;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          ofs_load = 1'b0;
    logic          ofs_sel = 1'b0;
    logic [AW-1:0] ofs_value = '0;
    logic          rd_en = 1'b0;
    logic          wr_block, half_full, almost_full;
    logic [DW-1:0] rd_data;
    logic          rd_stall, almost_empty;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    dsf_core #(.DATA_W(DW), .DEPTH(DEPTH), .OFS_DEFAULT(7)) u0 (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .cfg_code(cfg_code),
        .wr_en(wr_en), .wr_data(wr_data), .wr_block(wr_block),
        .half_full(half_full), .almost_full(almost_full),
        .ofs_load(ofs_load), .ofs_sel(ofs_sel), .ofs_value(ofs_value),
        .rd_en(rd_en), .rd_data(rd_data), .rd_stall(rd_stall),
        .almost_empty(almost_empty)
    );

    always #5 wclk = ~wclk;
    initial begin
        #0.3;
        forever #7 rclk = ~rclk;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] code, input logic [2:0] later);
        @(negedge wclk);
        rst_n = 1'b0; cfg_code = code; wr_en = 1'b0; rd_en = 1'b0; ofs_load = 1'b0;
        repeat (4) @(posedge rclk);
        @(negedge wclk);
        rst_n = 1'b1; cfg_code = later;
        repeat (4) @(posedge rclk);
        @(negedge wclk);
    endtask

    task automatic settle();
        repeat (6) @(posedge rclk);
        repeat (6) @(posedge wclk);
        @(negedge wclk);
    endtask

    task automatic wr_burst(input int n, input logic [DW-1:0] base);
        @(negedge wclk);
        wr_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            wr_data = base + DW'(i);
            @(negedge wclk);
        end
        wr_en = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge rclk);
        rd_en = 1'b1;
        @(negedge rclk);
        rd_en = 1'b0;
    endtask

    task automatic load_ofs(input logic sel, input logic [AW-1:0] val);
        @(negedge wclk);
        ofs_load = 1'b1; ofs_sel = sel; ofs_value = val;
        @(negedge wclk);
        ofs_load = 1'b0;
    endtask

    task automatic t_reset_std();
        do_reset(3'b010, 3'b101);
        chk("R2 rd_stall", 32'(rd_stall), 1);
        chk("R2 wr_block", 32'(wr_block), 0);
        chk("R2 half_full", 32'(half_full), 0);
        chk("R2 almost_full", 32'(almost_full), 0);
        chk("R2 almost_empty", 32'(almost_empty), 1);
        chk("R2 rd_data", 32'(rd_data), 0);
    endtask

    task automatic t_std_read();
        rd_pulse();
        chk("R6 empty read data", 32'(rd_data), 0);
        chk("R6 empty read stall", 32'(rd_stall), 1);
        wr_burst(1, 18'h11);
        repeat (4) @(posedge rclk);
        #1;
        chk("R3 stall latency", 32'(rd_stall), 0);
        chk("R1 code change ignored, no fall-through", 32'(rd_data), 0);
        wr_burst(2, 18'h12);
        settle();
        rd_pulse(); chk("R3 first word", 32'(rd_data), 32'h11);
        rd_pulse(); chk("R3 second word", 32'(rd_data), 32'h12);
        rd_pulse(); chk("R3 third word", 32'(rd_data), 32'h13);
        chk("R3 stall after drain", 32'(rd_stall), 1);
        rd_pulse();
        chk("R6 read on empty holds data", 32'(rd_data), 32'h13);
        wr_burst(1, 18'h14);
        settle();
        rd_pulse();
        chk("R6 order kept after refused read", 32'(rd_data), 32'h14);
    endtask

    task automatic t_fill();
        do_reset(3'b110, 3'b001);
        wr_burst(7, 18'h200); settle();
        chk("R9 almost_empty at 7", 32'(almost_empty), 1);
        wr_burst(1, 18'h207); settle();
        chk("R9 almost_empty at 8", 32'(almost_empty), 0);
        wr_burst(8, 18'h208); settle();
        chk("R7 half_full at 16", 32'(half_full), 0);
        wr_burst(1, 18'h210); settle();
        chk("R7 half_full at 17", 32'(half_full), 1);
        wr_burst(7, 18'h211); settle();
        chk("R8 almost_full at 24", 32'(almost_full), 0);
        wr_burst(1, 18'h218); settle();
        chk("R8 almost_full at 25", 32'(almost_full), 1);
        wr_burst(6, 18'h219); settle();
        chk("R5 wr_block at 31", 32'(wr_block), 0);
        wr_burst(1, 18'h21f); settle();
        chk("R5 wr_block at 32", 32'(wr_block), 1);
        wr_burst(1, 18'h3ff); settle();
        for (int i = 0; i < DEPTH; i++) begin
            rd_pulse();
            chk("R5 drain order", 32'(rd_data), 32'h200 + 32'(i));
        end
        settle();
        chk("R5 empty after DEPTH reads", 32'(rd_stall), 1);
        chk("R7 half_full after drain", 32'(half_full), 0);
        rd_pulse();
        chk("R5 dropped write absent", 32'(rd_data), 32'h21f);
    endtask

    task automatic t_load();
        do_reset(3'b000, 3'b000);
        load_ofs(1'b0, 5'd3);
        load_ofs(1'b1, 5'd2);
        settle();
        wr_burst(3, 18'h300); settle();
        chk("R10 almost_empty at 3, offset 3", 32'(almost_empty), 1);
        wr_burst(1, 18'h303); settle();
        chk("R10 almost_empty at 4, offset 3", 32'(almost_empty), 0);
        wr_burst(25, 18'h304); settle();
        chk("R10 almost_full at 29, offset 2", 32'(almost_full), 0);
        wr_burst(1, 18'h31d); settle();
        chk("R10 almost_full at 30, offset 2", 32'(almost_full), 1);
    endtask

    task automatic t_fall();
        do_reset(3'b101, 3'b010);
        chk("R4 stall after reset", 32'(rd_stall), 1);
        wr_burst(2, 18'h401); settle();
        chk("R4 first word without request", 32'(rd_data), 32'h401);
        chk("R4 ready", 32'(rd_stall), 0);
        chk("R9 presented word counted", 32'(almost_empty), 1);
        rd_pulse();
        chk("R4 next word", 32'(rd_data), 32'h402);
        chk("R4 still ready", 32'(rd_stall), 0);
        rd_pulse();
        chk("R4 stall after last", 32'(rd_stall), 1);
        chk("R6 data held", 32'(rd_data), 32'h402);
        rd_pulse();
        chk("R6 empty read in fall-through", 32'(rd_data), 32'h402);
        wr_burst(1, 18'h403); settle();
        chk("R4 refill falls through", 32'(rd_data), 32'h403);
        do_reset(3'b001, 3'b110);
        wr_burst(1, 18'h501); settle();
        chk("R1 code 001 is fall-through", 32'(rd_data), 32'h501);
    endtask

    initial begin
        t_reset_std();
        t_std_read();
        t_fill();
        t_load();
        t_fall();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #500us;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish (all requirements), actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule